// File: doc/BRIEF.md
# Stride-Based Result Validator

This block filters work for a redundant execution thread. It keeps a table indexed by instruction address. Each entry learns the last result an instruction produced and the step between its last two results. When a main-thread instruction completes, its address and result are presented on the lookup port. The block forms an expected value as last plus step and compares it with the result. It then emits one bit. A 1 tells the trailing thread to re-execute the instruction. A 0 lets the trailing thread drop its copy.

An entry is trusted only when three things hold: it is valid, its partial address tag matches, and its learned step is non-zero. An instruction whose value does not change is never validated, because a constant value is a weak sign that the computation was done correctly. The separate update port trains the table from committed results. An update to an untracked or aliased entry claims that entry and sets its step to zero.

Top module: `result_validator`

## Requirements
- R1: After reset `chk_valid` is 0 and every table entry is invalid, so the first lookup of any address gives `chk_reexec`=1.
- R2: `chk_valid` equals `lk_valid` of the previous cycle, and `chk_reexec` belongs to that lookup.
- R3: A lookup whose entry is invalid, or whose stored tag differs, gives `chk_reexec`=1.
- R4: A lookup that hits an entry with a zero step gives `chk_reexec`=1, even when the result equals the stored last value.
- R5: A lookup that hits, with a non-zero step and a result equal to last+step (modulo 2^DATA_W), gives `chk_reexec`=0.
- R6: A lookup that hits with a non-zero step and any other result gives `chk_reexec`=1.
- R7: An update that hits sets the step to the result minus the old last value (modulo 2^DATA_W), then stores the result as the last value.
- R8: An update that misses claims the entry: it stores the new tag, last = result, step = 0, and marks the entry valid.
- R9: When a lookup and an update reach the same entry in one cycle, the lookup uses the contents from before the update.
- R10: The entry index is PC[ALIGN+IDX_W-1:ALIGN], and the tag is the TAG_W bits right above it. Two addresses with the same index and different tags replace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A completed instruction is being checked |
| lk_pc | input | PC_W | Address of the checked instruction |
| lk_result | input | DATA_W | Result the instruction produced |
| up_valid | input | 1 | Train the table with a committed result |
| up_pc | input | PC_W | Address of the committed instruction |
| up_result | input | DATA_W | Committed result |
| chk_valid | output | 1 | `chk_reexec` holds a decision |
| chk_reexec | output | 1 | 1 = re-execute the instruction, 0 = the redundant copy may be dropped |

## Verification
Each decision comes from one register stage. The bench therefore drives a lookup before a rising edge and reads `chk_valid`/`chk_reexec` at the falling edge that follows. An update changes the table at that same edge. Its effect shows up first in a lookup driven in the next cycle, or in a later one. The bench reference model works out the expected bit from its own table state before it applies the update of the same cycle. This is how it covers the same-cycle ordering rule.

// File: rtl/rv_pkg.sv
package rv_pkg;
  parameter int RV_DATA_W = 32;

  typedef logic [RV_DATA_W-1:0] rv_data_t;

  typedef struct packed {
    rv_data_t last;
    rv_data_t step;
  } rv_entry_t;

  // expected result: last value advanced by one learned step
  function automatic rv_data_t rv_expect(input rv_data_t last, input rv_data_t step);
    return last + step;
  endfunction

  // learned step between the previous and the newly committed value
  function automatic rv_data_t rv_new_step(input rv_data_t result, input rv_data_t last);
    return result - last;
  endfunction
endpackage

// File: rtl/rv_addr_split.sv
module rv_addr_split #(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int IDX_W = 12,
  parameter int TAG_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[ALIGN +: IDX_W];

  generate
    if (ALIGN + IDX_W + TAG_W <= PC_W) begin : g_full_tag
      assign tag = pc[ALIGN + IDX_W +: TAG_W];
    end else begin : g_short_tag
      localparam int AVAIL = PC_W - ALIGN - IDX_W;
      assign tag = TAG_W'(pc[PC_W-1 -: AVAIL]);
    end
  endgenerate
endmodule

// File: rtl/rv_table.sv
module rv_table
  import rv_pkg::*;
#(
  parameter int ENTRIES = 4096,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup read
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output rv_entry_t        rd_entry,
  // training write
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  rv_data_t         wr_result
);
  rv_entry_t          ent_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic      wr_hit;
  rv_entry_t wr_old;
  rv_entry_t wr_next;

  assign rd_hit   = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_entry = ent_q[rd_idx];

  assign wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign wr_old = ent_q[wr_idx];

  always_comb begin
    wr_next.last = wr_result;
    wr_next.step = wr_hit ? rv_new_step(wr_result, wr_old.last) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_idx] <= wr_next;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  // R8: a claimed entry starts with no step
  a_r8_claim_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> (ent_q[$past(wr_idx)].step == '0));

  // R7: a trained entry keeps the committed value as its last value
  a_r7_last_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q[$past(wr_idx)].last == $past(wr_result)) && vld_q[$past(wr_idx)]);
endmodule

// File: rtl/result_validator.sv
module result_validator
  import rv_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DATA_W  = RV_DATA_W,
  parameter int ENTRIES = 4096,
  parameter int ALIGN   = 2,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [DATA_W-1:0] lk_result,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [DATA_W-1:0] up_result,
  output logic              chk_valid,
  output logic              chk_reexec
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_hit;
  rv_entry_t        lk_ent;

  rv_addr_split #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

  rv_addr_split #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
    .pc(up_pc), .idx(up_idx), .tag(up_tag));

  rv_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(lk_hit), .rd_entry(lk_ent),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_tag(up_tag), .wr_result(rv_data_t'(up_result)));

  // named events for the checks
  logic lk_zero_step;
  logic lk_match;
  logic lk_trust;
  assign lk_zero_step = (lk_ent.step == '0);
  assign lk_match     = (rv_data_t'(lk_result) == rv_expect(lk_ent.last, lk_ent.step));
  assign lk_trust     = lk_hit && !lk_zero_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      chk_reexec <= 1'b1;
    end else begin
      chk_valid  <= lk_valid;
      chk_reexec <= !(lk_trust && lk_match);
    end
  end

  // R2: one decision per lookup, one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid == $past(lk_valid));

  // R3: untracked or aliased address is always re-executed
  a_r3_miss_reexec: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |=> chk_reexec);

  // R4: zero step never validates
  a_r4_zero_step_reexec: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit && lk_zero_step) |=> chk_reexec);

  // R6: a dropped copy needs a matching prediction
  a_r6_drop_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_match) |=> chk_reexec);
endmodule

// File: tb/sim_result_validator.sv
module sim_result_validator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [31:0] lk_result = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [31:0] up_result = '0;
  logic        chk_valid;
  logic        chk_reexec;

  always #4 clk = ~clk;

  result_validator u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_result(lk_result),
    .up_valid(up_valid), .up_pc(up_pc), .up_result(up_result),
    .chk_valid(chk_valid), .chk_reexec(chk_reexec));

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference table, keyed by slot number
  bit [31:0] m_last [int];
  bit [31:0] m_step [int];
  int        m_tag  [int];

  function automatic int slot_of(input bit [31:0] pc);
    return int'((pc / 4) % 4096);
  endfunction
  function automatic int tag_of(input bit [31:0] pc);
    return int'((pc / 16384) % 256);
  endfunction

  function automatic bit model_reexec(input bit [31:0] pc, input bit [31:0] res);
    int s = slot_of(pc);
    if (!m_tag.exists(s)) return 1;
    if (m_tag[s] != tag_of(pc)) return 1;
    if (m_step[s] == 0) return 1;
    return !(res == m_last[s] + m_step[s]);
  endfunction

  task automatic model_train(input bit [31:0] pc, input bit [31:0] res);
    int s = slot_of(pc);
    if (m_tag.exists(s) && m_tag[s] == tag_of(pc)) begin
      m_step[s] = res - m_last[s];
    end else begin
      m_tag[s]  = tag_of(pc);
      m_step[s] = 0;
    end
    m_last[s] = res;
  endtask

  task automatic check(input bit act, input bit exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, expect after the next rising edge
  task automatic cyc(input bit lv, input bit [31:0] lpc, input bit [31:0] lres,
                     input bit uv, input bit [31:0] upc, input bit [31:0] ures,
                     input string req);
    bit exp;
    lk_valid = lv; lk_pc = lpc; lk_result = lres;
    up_valid = uv; up_pc = upc; up_result = ures;
    exp = lv ? model_reexec(lpc, lres) : 1'b0;   // old contents (R9)
    @(posedge clk);
    if (uv) model_train(upc, ures);
    @(negedge clk);
    check(chk_valid, lv, {req, " valid"});
    if (lv) check(chk_reexec, exp, req);
    lk_valid = 0; up_valid = 0;
  endtask

  localparam bit [31:0] PA = 32'h0000_1008;
  localparam bit [31:0] PB = PA + 32'h0000_4000;   // same slot, other tag
  localparam bit [31:0] PC2 = 32'h0000_2204;

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(chk_valid, 1'b0, "R1 reset valid");
    rst_n = 1;
    @(negedge clk);
    check(chk_valid, 1'b0, "R1 idle after reset");

    cyc(1, PA, 32'd0,   0, 0, 0,          "R1/R3 empty table");
    cyc(0, 0, 0,        1, PA, 32'd100,   "R8 claim");
    cyc(1, PA, 32'd100, 0, 0, 0,          "R4 zero step equal value");
    cyc(0, 0, 0,        1, PA, 32'd110,   "R7 train step 10");
    cyc(1, PA, 32'd120, 0, 0, 0,          "R5 predicted match");
    cyc(1, PA, 32'd121, 0, 0, 0,          "R6 mismatch");
    cyc(1, PA, 32'd120, 1, PA, 32'd120,   "R9 same-cycle old view");
    cyc(1, PA, 32'd130, 0, 0, 0,          "R7 after same-cycle train");
    cyc(1, PB, 32'd140, 0, 0, 0,          "R10 alias miss");
    cyc(0, 0, 0,        1, PB, 32'd5,     "R10 alias claim");
    cyc(1, PA, 32'd130, 0, 0, 0,          "R10 replaced entry misses");
    cyc(0, 0, 0,        1, PB, 32'd3,     "R7 negative step");
    cyc(1, PB, 32'd1,   0, 0, 0,          "R5 negative step match");
    cyc(0, 0, 0,        1, PB, 32'd1,     "R7 train");
    cyc(1, PB, 32'hFFFF_FFFF, 0, 0, 0,    "R5 wraparound match");
    cyc(1, PC2, 32'd7,  1, PC2, 32'd7,    "R9 miss then claim");
    cyc(1, PC2, 32'd7,  0, 0, 0,          "R4 claimed zero step");

    begin
      bit [15:0] lf = 16'hACE1;
      bit [31:0] pcs [4] = '{PA, PB, PC2, 32'h0000_3FFC};
      for (int i = 0; i < 400; i++) begin
        bit [31:0] lpc, upc, lres, ures;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lpc  = pcs[lf[1:0]];
        upc  = pcs[lf[3:2]];
        lres = {28'd0, lf[7:4]};
        ures = {28'd0, lf[11:8]};
        cyc(lf[12], lpc, lres, lf[13], upc, ures, "R2-mix R5 R6 R7 R8 R9");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule